// File: doc/BRIEF.md
# Ripple and Domino Shrink Search Sequencer

This block steers a speed-path search across a span of test vectors. Software programs a first vector, a last vector, a block size and a search policy, then issues a start. The sequencer marks a window of vectors as "shrunk" (tightened timing), asks an external test executor to perform one functional run, and waits for its pass or fail verdict. After each passing run it moves on to the next block. It halts on the first failing run, or when the last vector has been covered.

Two policies share the controller. In ripple mode only the current block is shrunk, and the block before it falls back to base timing. In domino mode every block already visited stays shrunk, so the tightened region grows from the first vector. When a run fails, the block that was added last is latched as the failure report. An undo command drops every shrink assignment at once and returns the setup to all-base timing. A combinational query port tells the executor whether any given vector number is currently shrunk.

Top module: `shrink_search_seq`

## Requirements
- R1: A start accepted while idle or halted loads the window with low bound = first vector and high bound = min(first + step - 1, last). The cycle after the start edge, `run_req_o` is high for exactly one cycle.
- R2: In ripple mode (`mode_i` = 0), `query_hit_o` is 1 exactly when the shrink assignment is active and win_lo <= `query_vec_i` <= win_hi.
- R3: In domino mode (`mode_i` = 1), `query_hit_o` is 1 exactly when the shrink assignment is active and first <= `query_vec_i` <= win_hi.
- R4: A passing verdict (`run_done_i` = 1, `run_fail_i` = 0) on a block whose high bound is below the last vector moves the window to low = old high + 1 and high = min(old high + step, last). It then issues a new one-cycle `run_req_o`.
- R5: A failing verdict halts the search. It sets `fail_found_o`, copies the current window into `fail_lo_o`/`fail_hi_o`, keeps the window shrunk and drops `busy_o`.
- R6: A passing verdict on a block that reaches the last vector halts with `done_nofail_o` = 1. A final block shorter than the step is clipped to the last vector.
- R7: Undo removes every shrink assignment (`shrink_active_o` = 0, every query misses) and aborts any pending run, leaving `busy_o` = 0. In the same cycle it takes precedence over a verdict and over a start. The failure report is kept.
- R8: A start while a run is being launched or awaited is ignored, and the window does not change.
- R9: A step of 0 is treated as a step of 1.
- R10: After reset, `run_req_o`, `busy_o`, `shrink_active_o`, `fail_found_o`, `done_nofail_o` and `query_hit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search with the programmed range |
| undo_i | input | 1 | Drop all shrink assignments and abort |
| mode_i | input | 1 | 0 = ripple, 1 = domino (sampled at start) |
| first_vec_i | input | VEC_W | First vector of the range (sampled at start) |
| last_vec_i | input | VEC_W | Last vector of the range (sampled at start) |
| step_i | input | VEC_W | Block size in vectors (sampled at start) |
| run_req_o | output | 1 | One-cycle request for a functional run |
| run_done_i | input | 1 | Executor verdict valid |
| run_fail_i | input | 1 | Verdict is fail (with run_done_i) |
| win_lo_o | output | VEC_W | Low bound of the current block |
| win_hi_o | output | VEC_W | High bound of the current block |
| shrink_active_o | output | 1 | Shrink assignment in force |
| busy_o | output | 1 | Run being launched or awaited |
| fail_found_o | output | 1 | Last search stopped on a fail |
| done_nofail_o | output | 1 | Last search covered the range with no fail |
| fail_lo_o | output | VEC_W | Low bound of the failing block |
| fail_hi_o | output | VEC_W | High bound of the failing block |
| query_vec_i | input | VEC_W | Vector number to test |
| query_hit_o | output | 1 | Queried vector is shrunk |

## Verification
Undo can arrive in the same cycle as the executor's verdict, and a start can arrive while a run is pending. The bench drives undo together with a failing verdict and then checks at the ports that no failure was recorded, that the controller is idle and that the previously shrunk vector now misses. It also pulses a start with a different first vector during a launch and checks that the window is still the original one, both straight after the pulse and after the next advance.

// File: rtl/shrink_pkg.sv
package shrink_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_HALT   = 2'd3
  } seq_state_e;

  // A zero step behaves as one vector per block.
  function automatic logic [31:0] eff_step(input logic [31:0] step);
    return (step == 32'd0) ? 32'd1 : step;
  endfunction

  // High bound of a block starting at lo, clipped to last.
  function automatic logic [31:0] block_hi(input logic [31:0] lo,
                                           input logic [31:0] step,
                                           input logic [31:0] last);
    logic [32:0] sum;
    sum = {1'b0, lo} + {1'b0, eff_step(step)} - 33'd1;
    return (sum >= {1'b0, last}) ? last : sum[31:0];
  endfunction

  function automatic logic in_range(input logic [31:0] n,
                                    input logic [31:0] lo,
                                    input logic [31:0] hi);
    return (n >= lo) && (n <= hi);
  endfunction

endpackage

// File: rtl/shrink_ctrl.sv
module shrink_ctrl
  import shrink_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic undo_i,
  input  logic run_done_i,
  input  logic run_fail_i,
  input  logic at_end_i,
  output logic load_evt_o,
  output logic adv_evt_o,
  output logic fail_evt_o,
  output logic end_evt_o,
  output logic run_req_o,
  output logic busy_o
);

  seq_state_e state_q, state_d;
  logic       verdict;

  assign busy_o     = (state_q == ST_LAUNCH) || (state_q == ST_WAIT);
  assign run_req_o  = (state_q == ST_LAUNCH);
  assign load_evt_o = start_i && !undo_i && !busy_o;
  assign verdict    = (state_q == ST_WAIT) && run_done_i && !undo_i;
  assign fail_evt_o = verdict && run_fail_i;
  assign end_evt_o  = verdict && !run_fail_i && at_end_i;
  assign adv_evt_o  = verdict && !run_fail_i && !at_end_i;

  always_comb begin
    state_d = state_q;
    if (undo_i)                         state_d = ST_IDLE;
    else if (load_evt_o)                state_d = ST_LAUNCH;
    else if (state_q == ST_LAUNCH)      state_d = ST_WAIT;
    else if (fail_evt_o || end_evt_o)   state_d = ST_HALT;
    else if (adv_evt_o)                 state_d = ST_LAUNCH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/shrink_window.sv
module shrink_window
  import shrink_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt_i,
  input  logic             adv_evt_i,
  input  logic             undo_i,
  input  logic             mode_i,
  input  logic [VEC_W-1:0] first_i,
  input  logic [VEC_W-1:0] last_i,
  input  logic [VEC_W-1:0] step_i,
  output logic [VEC_W-1:0] lo_o,
  output logic [VEC_W-1:0] hi_o,
  output logic [VEC_W-1:0] first_o,
  output logic [VEC_W-1:0] last_o,
  output logic             mode_o,
  output logic             active_o,
  output logic             at_end_o
);

  localparam int PAD = 32 - VEC_W;

  logic [VEC_W-1:0] step_q;
  logic [31:0]      load_hi, adv_lo, adv_hi;

  assign load_hi  = block_hi({{PAD{1'b0}}, first_i}, {{PAD{1'b0}}, step_i},
                             {{PAD{1'b0}}, last_i});
  assign adv_lo   = {{PAD{1'b0}}, hi_o} + 32'd1;
  assign adv_hi   = block_hi(adv_lo, {{PAD{1'b0}}, step_q}, {{PAD{1'b0}}, last_o});
  assign at_end_o = (hi_o >= last_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_o     <= '0;
      hi_o     <= '0;
      first_o  <= '0;
      last_o   <= '0;
      step_q   <= '0;
      mode_o   <= 1'b0;
      active_o <= 1'b0;
    end else if (undo_i) begin
      active_o <= 1'b0;
    end else if (load_evt_i) begin
      lo_o     <= first_i;
      hi_o     <= load_hi[VEC_W-1:0];
      first_o  <= first_i;
      last_o   <= last_i;
      step_q   <= step_i;
      mode_o   <= mode_i;
      active_o <= 1'b1;
    end else if (adv_evt_i) begin
      lo_o <= adv_lo[VEC_W-1:0];
      hi_o <= adv_hi[VEC_W-1:0];
    end
  end

endmodule

// File: rtl/shrink_report.sv
module shrink_report #(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt_i,
  input  logic             fail_evt_i,
  input  logic             end_evt_i,
  input  logic [VEC_W-1:0] lo_i,
  input  logic [VEC_W-1:0] hi_i,
  output logic             fail_found_o,
  output logic             done_nofail_o,
  output logic [VEC_W-1:0] fail_lo_o,
  output logic [VEC_W-1:0] fail_hi_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_found_o  <= 1'b0;
      done_nofail_o <= 1'b0;
      fail_lo_o     <= '0;
      fail_hi_o     <= '0;
    end else if (load_evt_i) begin
      fail_found_o  <= 1'b0;
      done_nofail_o <= 1'b0;
    end else if (fail_evt_i) begin
      fail_found_o <= 1'b1;
      fail_lo_o    <= lo_i;
      fail_hi_o    <= hi_i;
    end else if (end_evt_i) begin
      done_nofail_o <= 1'b1;
    end
  end

endmodule

// File: rtl/shrink_query.sv
module shrink_query
  import shrink_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             active_i,
  input  logic             mode_i,
  input  logic [VEC_W-1:0] first_i,
  input  logic [VEC_W-1:0] lo_i,
  input  logic [VEC_W-1:0] hi_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             hit_o
);

  localparam int PAD = 32 - VEC_W;

  logic [VEC_W-1:0] base_lo;

  // Domino keeps everything from the first vector; ripple only the block.
  assign base_lo = mode_i ? first_i : lo_i;
  assign hit_o   = active_i && in_range({{PAD{1'b0}}, vec_i},
                                        {{PAD{1'b0}}, base_lo},
                                        {{PAD{1'b0}}, hi_i});

endmodule

// File: rtl/shrink_search_seq.sv
module shrink_search_seq #(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             undo_i,
  input  logic             mode_i,
  input  logic [VEC_W-1:0] first_vec_i,
  input  logic [VEC_W-1:0] last_vec_i,
  input  logic [VEC_W-1:0] step_i,
  output logic             run_req_o,
  input  logic             run_done_i,
  input  logic             run_fail_i,
  output logic [VEC_W-1:0] win_lo_o,
  output logic [VEC_W-1:0] win_hi_o,
  output logic             shrink_active_o,
  output logic             busy_o,
  output logic             fail_found_o,
  output logic             done_nofail_o,
  output logic [VEC_W-1:0] fail_lo_o,
  output logic [VEC_W-1:0] fail_hi_o,
  input  logic [VEC_W-1:0] query_vec_i,
  output logic             query_hit_o
);

  logic             load_evt, adv_evt, fail_evt, end_evt, at_end;
  logic             mode_q;
  logic [VEC_W-1:0] first_q, last_q;

  shrink_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .undo_i     (undo_i),
    .run_done_i (run_done_i),
    .run_fail_i (run_fail_i),
    .at_end_i   (at_end),
    .load_evt_o (load_evt),
    .adv_evt_o  (adv_evt),
    .fail_evt_o (fail_evt),
    .end_evt_o  (end_evt),
    .run_req_o  (run_req_o),
    .busy_o     (busy_o)
  );

  shrink_window #(.VEC_W(VEC_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_evt_i (load_evt),
    .adv_evt_i  (adv_evt),
    .undo_i     (undo_i),
    .mode_i     (mode_i),
    .first_i    (first_vec_i),
    .last_i     (last_vec_i),
    .step_i     (step_i),
    .lo_o       (win_lo_o),
    .hi_o       (win_hi_o),
    .first_o    (first_q),
    .last_o     (last_q),
    .mode_o     (mode_q),
    .active_o   (shrink_active_o),
    .at_end_o   (at_end)
  );

  shrink_report #(.VEC_W(VEC_W)) u_report (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_evt_i    (load_evt),
    .fail_evt_i    (fail_evt),
    .end_evt_i     (end_evt),
    .lo_i          (win_lo_o),
    .hi_i          (win_hi_o),
    .fail_found_o  (fail_found_o),
    .done_nofail_o (done_nofail_o),
    .fail_lo_o     (fail_lo_o),
    .fail_hi_o     (fail_hi_o)
  );

  shrink_query #(.VEC_W(VEC_W)) u_query (
    .active_i (shrink_active_o),
    .mode_i   (mode_q),
    .first_i  (first_q),
    .lo_i     (win_lo_o),
    .hi_i     (win_hi_o),
    .vec_i    (query_vec_i),
    .hit_o    (query_hit_o)
  );

endmodule

// File: rtl/shrink_search_chk.sv
module shrink_search_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             undo_i,
  input logic             run_done_i,
  input logic             run_req_o,
  input logic             busy_o,
  input logic             shrink_active_o,
  input logic             fail_found_o,
  input logic             done_nofail_o,
  input logic             adv_evt,
  input logic             fail_evt,
  input logic             end_evt,
  input logic [VEC_W-1:0] win_lo_o,
  input logic [VEC_W-1:0] win_hi_o,
  input logic [VEC_W-1:0] fail_lo_o,
  input logic [VEC_W-1:0] fail_hi_o,
  input logic [VEC_W-1:0] last_q
);

  a_r1_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    run_req_o |=> !run_req_o);

  a_r4_next_block: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (win_lo_o == $past(win_hi_o) + 1'b1) && run_req_o);

  a_r5_fail_latch: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> fail_found_o && !busy_o && shrink_active_o &&
                 (fail_lo_o == $past(win_lo_o)) && (fail_hi_o == $past(win_hi_o)));

  a_r6_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> done_nofail_o && !busy_o && (win_hi_o == last_q));

  a_r6_hi_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_active_o |-> (win_hi_o <= last_q));

  a_r7_undo_clears: assert property (@(posedge clk) disable iff (!rst_n)
    undo_i |=> !shrink_active_o && !busy_o && !run_req_o);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !undo_i && !run_done_i) |=>
      $stable(win_lo_o) && $stable(win_hi_o));

endmodule

bind shrink_search_seq shrink_search_chk #(.VEC_W(VEC_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .undo_i          (undo_i),
  .run_done_i      (run_done_i),
  .run_req_o       (run_req_o),
  .busy_o          (busy_o),
  .shrink_active_o (shrink_active_o),
  .fail_found_o    (fail_found_o),
  .done_nofail_o   (done_nofail_o),
  .adv_evt         (adv_evt),
  .fail_evt        (fail_evt),
  .end_evt         (end_evt),
  .win_lo_o        (win_lo_o),
  .win_hi_o        (win_hi_o),
  .fail_lo_o       (fail_lo_o),
  .fail_hi_o       (fail_hi_o),
  .last_q          (last_q)
);

// File: tb/shrink_search_seq_test.sv
module shrink_search_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic         mode;
    logic [W-1:0] first;
    logic [W-1:0] last;
    logic [W-1:0] step;
    logic [W-1:0] failrun;   // 1-based run index that fails, 0 = none
    logic [W-1:0] elo;
    logic [W-1:0] ehi;
    logic [W-1:0] eruns;
    logic         efail;
  } case_t;

  localparam int NCASE = 7;
  localparam case_t CASES [NCASE] = '{
    '{1'b0, 16'd920,  16'd3000, 16'd100, 16'd16, 16'd2420, 16'd2519, 16'd16, 1'b1},
    '{1'b1, 16'd920,  16'd3000, 16'd100, 16'd16, 16'd2420, 16'd2519, 16'd16, 1'b1},
    '{1'b0, 16'd2420, 16'd2519, 16'd1,   16'd68, 16'd2487, 16'd2487, 16'd68, 1'b1},
    '{1'b0, 16'd10,   16'd25,   16'd4,   16'd0,  16'd22,   16'd25,   16'd4,  1'b0},
    '{1'b1, 16'd10,   16'd24,   16'd4,   16'd0,  16'd22,   16'd24,   16'd4,  1'b0},
    '{1'b0, 16'd5,    16'd7,    16'd0,   16'd0,  16'd7,    16'd7,    16'd3,  1'b0},
    '{1'b1, 16'd0,    16'd9,    16'd20,  16'd1,  16'd0,    16'd9,    16'd1,  1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, undo_i = 1'b0, mode_i = 1'b0;
  logic [W-1:0] first_vec_i = '0, last_vec_i = '0, step_i = '0, query_vec_i = '0;
  logic run_done_i = 1'b0, run_fail_i = 1'b0;
  logic run_req_o, shrink_active_o, busy_o, fail_found_o, done_nofail_o, query_hit_o;
  logic [W-1:0] win_lo_o, win_hi_o, fail_lo_o, fail_hi_o;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shrink_search_seq #(.VEC_W(W)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic query(input logic [W-1:0] n, output logic hit);
    query_vec_i = n;
    #1 hit = query_hit_o;
  endtask

  task automatic go(input logic m, input logic [W-1:0] f, input logic [W-1:0] l,
                    input logic [W-1:0] s);
    @(negedge clk);
    mode_i = m; first_vec_i = f; last_vec_i = l; step_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Walk one search, acting as executor, checking every window.
  task automatic run_case(input case_t c);
    int s, lo, hi, k, guard;
    logic h;
    s  = (c.step == 0) ? 1 : int'(c.step);
    lo = int'(c.first);
    hi = (lo + s - 1 > int'(c.last)) ? int'(c.last) : lo + s - 1;
    k  = 0;
    go(c.mode, c.first, c.last, c.step);
    guard = 0;
    while (1) begin
      check(k == 0 ? "R1 run_req after start" : "R4 run_req after pass", run_req_o, 1);
      check(k == 0 ? "R1 first lo" : "R4 next lo", win_lo_o, lo);
      check(k == 0 ? "R1 first hi" : (c.step == 0 ? "R9 zero step hi" : "R4 next hi"),
            win_hi_o, hi);
      k++;
      @(negedge clk);
      if (k == 1) check("R1 run_req one cycle", run_req_o, 0);
      run_done_i = 1'b1;
      run_fail_i = (k == int'(c.failrun));
      @(negedge clk);
      run_done_i = 1'b0; run_fail_i = 1'b0;
      if (!busy_o) break;
      lo = hi + 1;
      hi = (hi + s > int'(c.last)) ? int'(c.last) : hi + s;
      guard++;
      if (guard > 1000) break;
    end
    check("R5/R6 run count", k, c.eruns);
    check("R5 fail flag", fail_found_o, c.efail);
    check("R6 done flag", done_nofail_o, !c.efail);
    check("R6 clipped lo", win_lo_o, c.elo);
    check("R6 clipped hi", win_hi_o, c.ehi);
    if (c.efail) begin
      check("R5 fail lo", fail_lo_o, c.elo);
      check("R5 fail hi", fail_hi_o, c.ehi);
    end
    query(c.elo, h);
    check(c.mode ? "R3 query in block" : "R2 query in block", h, 1);
    query(c.ehi + 16'd1, h);
    check(c.mode ? "R3 query above" : "R2 query above", h, 0);
    query(c.elo - 16'd1, h);
    check(c.mode ? "R3 query below block" : "R2 query below block", h,
          c.mode && (c.elo > c.first));
    query(c.first, h);
    check(c.mode ? "R3 query first" : "R2 query first", h, c.mode || (c.elo == c.first));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic h;
    #1;
    check("R10 run_req in reset", run_req_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 run_req", run_req_o, 0);
    check("R10 busy", busy_o, 0);
    check("R10 active", shrink_active_o, 0);
    check("R10 fail flag", fail_found_o, 0);
    check("R10 done flag", done_nofail_o, 0);
    query(16'd0, h);
    check("R10 query", h, 0);

    for (int i = 0; i < NCASE; i++) run_case(CASES[i]);

    // R7: undo after a failing search; report kept, nothing shrunk.
    @(negedge clk); undo_i = 1'b1;
    @(negedge clk); undo_i = 1'b0;
    check("R7 active after undo", shrink_active_o, 0);
    check("R7 report kept", fail_found_o, 1);
    check("R7 fail hi kept", fail_hi_o, 9);
    query(16'd3, h);
    check("R7 query after undo", h, 0);

    // R8: start during a launch is ignored.
    go(1'b0, 16'd100, 16'd199, 16'd10);
    start_i = 1'b1; first_vec_i = 16'd500;
    @(negedge clk);
    start_i = 1'b0;
    check("R8 lo unchanged", win_lo_o, 100);
    check("R8 still busy", busy_o, 1);
    run_done_i = 1'b1;
    @(negedge clk);
    run_done_i = 1'b0;
    check("R8 next lo from original range", win_lo_o, 110);
    // R7: undo in the same cycle as a failing verdict and a start.
    @(negedge clk);
    run_done_i = 1'b1; run_fail_i = 1'b1; undo_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    run_done_i = 1'b0; run_fail_i = 1'b0; undo_i = 1'b0; start_i = 1'b0;
    check("R7 verdict discarded", fail_found_o, 0);
    check("R7 busy after undo", busy_o, 0);
    check("R7 active after collision", shrink_active_o, 0);
    query(16'd110, h);
    check("R7 query after collision", h, 0);
    @(negedge clk);
    check("R7 no run after undo", run_req_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule